// File: doc/BRIEF.md
# Double-Buffered Slave-Clocked Serial Transmitter

This block is the transmit side of a synchronous serial port. A host loads a one-word holding register through a single-cycle write strobe. The block moves that word into a shift register and sends it out on a serial data pin, least significant bit first. In slave mode the shift clock comes from an external pin. That pin is synchronised into the system clock domain, and only its falling edges advance the data. A receiver can therefore sample the data line on the rising edge of the same external clock.

The holding register and the shift register are separate. The host can queue the next word while a frame is still going out. When a frame finishes, the queued word moves into the shift register after a fixed two-cycle gap, during which the line is held high, and no completion pulse is given. A completion pulse appears only when a frame ends with nothing queued. A mode input selects an internal divided clock instead of the external pin. If the external clock stalls part-way through a frame, this mode pushes the stuck frame, and any queued word, out of the block.

Top module: `slvtx_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, all state clears. Afterwards `txd` is 1, both pulse outputs are 0, `mst_sck` is 1, and the holding register is empty.
- R2: Suppose a write strobe is sampled at edge E while the transmitter is idle. The word moves into the shift register at edge E+1, and `buf_empty_pulse` is 1 for exactly the one cycle that follows E+1.
- R3: `ext_sck` passes through two synchronising flops. A falling edge is detected when the first low sample follows a high sample. `txd` changes at the second clock edge after the edge that first samples `ext_sck` low.
- R4: Bits leave least significant first. The first bit is driven on the first detected falling shift-clock edge after the load. Until then `txd` stays 1. `txd` never changes except on a detected falling shift-clock edge.
- R5: The frame length is read from `frame_len` when a word is loaded, and later changes do not affect that frame. The values 1 to DW give that many bits. The value 0, or any value above DW, gives DW bits.
- R6: The falling edge that follows the last bit ends the frame. On that edge `txd` returns to 1 and a two-cycle gap starts. Falling edges detected during the gap are ignored.
- R7: If the holding register is full when the gap ends, its word loads at once. `buf_empty_pulse` fires and `done_pulse` does not.
- R8: If the holding register is empty when the gap ends, `done_pulse` is 1 for one cycle and the block returns to idle.
- R9: With `slave_mode` at 0, an internal divider supplies the shift clock. `mst_sck` has a high and low phase of MHALF cycles each, and `txd` changes on its falling edges. This mode drains a frame stalled by a stopped external clock, including a queued word. Slave mode then works normally again.
- R10: A write while the holding register is full replaces the waiting word. Only the last word written before the load is sent.
- R11: While `slave_mode` is 1, `mst_sck` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_mode | input | 1 | 1: external shift clock; 0: internal divided clock |
| frame_len | input | LW ($clog2(DW+1)) | Bits per frame, read at load (0 or above DW means DW) |
| wr_en | input | 1 | One-cycle write strobe into the holding register |
| wr_data | input | DW | Word to transmit |
| ext_sck | input | 1 | External shift clock (asynchronous) |
| mst_sck | output | 1 | Internal shift clock, high in slave mode |
| txd | output | 1 | Serial data, idles high |
| buf_empty_pulse | output | 1 | One-cycle pulse when the holding register is emptied into the shifter |
| done_pulse | output | 1 | One-cycle pulse when a frame ends with nothing queued |

## Verification
The embedded assertions check several rules on every cycle:
- the data line moves only on a detected shift-clock edge and is high outside a frame;
- detected edges and both pulses last one cycle, and the two pulses never coincide;
- a write always leaves the holding register full with the new word;
- the internal clock stays high in slave mode.

Some behaviours only the bench scenarios can show: the exact two-edge latency from the external pin, bit order and frame length, the choice between reload and completion at the end of a gap, ignoring an edge that falls inside the gap, overwrite of a queued word, and draining a stalled frame through the internal clock.

// File: rtl/slvtx_pkg.sv
// Package: shared state type and frame-length rule for the serial transmitter.
// Assumes: lengths are small non-negative integers.
package slvtx_pkg;

    // Transmitter sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAPA = 2'd2,
        ST_GAPB = 2'd3
    } tx_state_e;

    // Map a requested length onto 1..maxv; zero or oversize selects maxv.
    function automatic int unsigned fit_len(input int unsigned req, input int unsigned maxv);
        return ((req == 0) || (req > maxv)) ? maxv : req;
    endfunction

endpackage

// File: rtl/slvtx_sckdet.sv
// Module: synchroniser and falling-edge detector for the external shift clock.
// Assumes: pin is asynchronous to clk and idles high; SYNC >= 2 stages.
// fall is a one-cycle pulse when the synchronised pin goes from 1 to 0.
module slvtx_sckdet #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);

    logic [SYNC:0] chain_q;

    // Shift the pin through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[SYNC-1:0], pin};
    end

    // Edge seen when the older sample is high and the newer one low.
    assign fall = chain_q[SYNC] & ~chain_q[SYNC-1];

    // R3: a detected edge cannot repeat on the next cycle.
    a_r3_fall_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/slvtx_mclk.sv
// Module: internal shift-clock divider used when the external clock is not selected.
// Assumes: HALF >= 1; held high and reset while slave mode is selected.
// tick marks the clk edge on which the divided clock falls.
module slvtx_mclk #(
    parameter int HALF = 3,
    localparam int CW = $clog2(HALF + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slave,
    output logic sck,
    output logic tick
);

    logic [CW-1:0] cnt_q;
    logic          sck_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF - 1));

    // Count half periods and toggle the clock; parked high in slave mode.
    always_ff @(posedge clk) begin
        if (!rst_n || slave) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end else if (wrap) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign sck  = sck_q;
    assign tick = !slave && wrap && sck_q;

    // R11: slave mode keeps the internal clock high.
    a_r11_slave_high: assert property (@(posedge clk) disable iff (!rst_n)
        slave |=> sck_q);
    // R9: internal shift events only exist in master mode and coincide with a fall.
    a_r9_tick_falls: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!sck_q && !slave) || $past(slave) || slave);

endmodule

// File: rtl/slvtx_hold.sv
// Module: one-word holding register between host and shifter.
// Assumes: a write in the same cycle as a take wins; the take reads the old word.
module slvtx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);

    logic          full_q;
    logic [DW-1:0] data_q;

    // Capture host writes and release the slot when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (wr_en) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign full = full_q;
    assign data = data_q;

    // R10: any write leaves the slot full with the newest word.
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full_q && (data_q == $past(wr_data)));

endmodule

// File: rtl/slvtx_shift.sv
// Module: frame shifter and sequencer (load, shift, two-cycle gap, reload or finish).
// Assumes: tick is a one-cycle shift event; hold slot is offered through full/hold_data.
module slvtx_shift
    import slvtx_pkg::*;
#(
    parameter int DW = 8,
    localparam int LW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          full,
    input  logic [DW-1:0] hold_data,
    input  logic [LW-1:0] flen,
    output logic          take,
    output logic          txd,
    output logic          empty_p,
    output logic          done_p
);

    tx_state_e     st_q;
    logic [DW-1:0] sh_q;
    logic [LW-1:0] cnt_q;
    logic [LW-1:0] nbits_q;
    logic          txd_q;
    logic          emp_q;
    logic          done_q;
    logic [LW-1:0] eff_len;

    // Resolve the requested length for the word about to load.
    assign eff_len = LW'(fit_len(int'(flen), DW));

    // A waiting word is accepted when idle or at the end of the gap.
    assign take = full && ((st_q == ST_IDLE) || (st_q == ST_GAPB));

    // Sequence the frame: load, shift on ticks, close with gap, then reload or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            nbits_q <= '0;
            txd_q   <= 1'b1;
            emp_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            emp_q  <= 1'b0;
            done_q <= 1'b0;
            if (take) begin
                sh_q    <= hold_data;
                cnt_q   <= '0;
                nbits_q <= eff_len;
                st_q    <= ST_RUN;
                emp_q   <= 1'b1;
            end else begin
                case (st_q)
                    ST_RUN: begin
                        if (tick) begin
                            if (cnt_q == nbits_q) begin
                                txd_q <= 1'b1;
                                st_q  <= ST_GAPA;
                            end else begin
                                txd_q <= sh_q[0];
                                sh_q  <= sh_q >> 1;
                                cnt_q <= cnt_q + LW'(1);
                            end
                        end
                    end
                    ST_GAPA: st_q <= ST_GAPB;
                    ST_GAPB: begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign txd     = txd_q;
    assign empty_p = emp_q;
    assign done_p  = done_q;

    // R4: the line moves only in response to a shift event.
    a_r4_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd_q));
    // R6: outside an active frame the line is high.
    a_r6_high_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN) |-> txd_q);
    // R5: the bit count never passes the length captured at load.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= nbits_q);
    // R2: the buffer-empty indication lasts a single cycle.
    a_r2_empty_single: assert property (@(posedge clk) disable iff (!rst_n)
        emp_q |=> !emp_q);

endmodule

// File: rtl/slvtx_top.sv
// Module: top of the double-buffered serial transmitter with selectable shift clock.
// Assumes: ext_sck is asynchronous; mode and frame length change only between frames
// except when draining a stalled frame through master mode.
module slvtx_top #(
    parameter int DW    = 8,
    parameter int SYNC  = 2,
    parameter int MHALF = 3,
    localparam int LW   = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slave_mode,
    input  logic [LW-1:0] frame_len,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ext_sck,
    output logic          mst_sck,
    output logic          txd,
    output logic          buf_empty_pulse,
    output logic          done_pulse
);

    logic          ext_fall;
    logic          int_fall;
    logic          shift_ev;
    logic          take;
    logic          full;
    logic [DW-1:0] hold_data;

    slvtx_sckdet #(.SYNC(SYNC)) u_det (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_sck),
        .fall (ext_fall)
    );

    slvtx_mclk #(.HALF(MHALF)) u_mclk (
        .clk  (clk),
        .rst_n(rst_n),
        .slave(slave_mode),
        .sck  (mst_sck),
        .tick (int_fall)
    );

    // Pick the shift-event source from the mode input.
    assign shift_ev = slave_mode ? ext_fall : int_fall;

    slvtx_hold #(.DW(DW)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .take   (take),
        .full   (full),
        .data   (hold_data)
    );

    slvtx_shift #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (shift_ev),
        .full     (full),
        .hold_data(hold_data),
        .flen     (frame_len),
        .take     (take),
        .txd      (txd),
        .empty_p  (buf_empty_pulse),
        .done_p   (done_pulse)
    );

    // R7: a reload and a completion never occur together.
    a_r7_no_done_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !buf_empty_pulse);
    // R8: completion is a single-cycle pulse.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

endmodule

// File: tb/tb_slvtx_top.sv
module tb_slvtx_top;
    localparam int DW = 8;
    localparam int MHALF = 3;
    localparam int LW = $clog2(DW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b1;
    logic [LW-1:0] frame_len = LW'(8);
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          ext_sck = 1'b1;
    logic          mst_sck, txd, buf_empty_pulse, done_pulse;

    always #4 clk = ~clk;

    slvtx_top #(.DW(DW), .SYNC(2), .MHALF(MHALF)) dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .frame_len(frame_len),
        .wr_en(wr_en), .wr_data(wr_data), .ext_sck(ext_sck), .mst_sck(mst_sck),
        .txd(txd), .buf_empty_pulse(buf_empty_pulse), .done_pulse(done_pulse)
    );

    int    checks = 0;
    int    fails = 0;
    int    n_done = 0;
    int    n_emp = 0;
    bit    finished = 0;
    bit    mdl_on = 1;
    string cur_req = "R1";
    bit    caps[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Behavioural reference: pending bits in a queue, sampled pin history, gap counter.
    int         m_st;
    bit         m_full;
    logic [7:0] m_hold;
    bit         m_txd, m_emp, m_done;
    bit         m_s1, m_s2, m_s3;
    bit         bitq[$];

    always @(posedge clk) begin : mdl
        bit         tk;
        bit         tak;
        logic [7:0] old;
        int         n;
        if (!rst_n) begin
            m_st = 0; m_full = 0; m_hold = '0; m_txd = 1; m_emp = 0; m_done = 0;
            m_s1 = 1; m_s2 = 1; m_s3 = 1; bitq.delete();
        end else begin
            tk = m_s3 && !m_s2 && slave_mode;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_sck;
            if (!mdl_on) begin
                m_st = 0; m_full = 0; m_txd = 1; m_emp = 0; m_done = 0; bitq.delete();
            end else begin
                tak = m_full && (m_st == 0 || m_st == 3);
                old = m_hold;
                m_emp = 0; m_done = 0;
                if (tak) begin
                    n = (frame_len == 0 || frame_len > DW) ? DW : int'(frame_len);
                    bitq.delete();
                    for (int i = 0; i < n; i++) bitq.push_back(old[i]);
                    m_st = 1; m_emp = 1;
                end else if (m_st == 1) begin
                    if (tk) begin
                        if (bitq.size() == 0) begin m_txd = 1; m_st = 2; end
                        else m_txd = bitq.pop_front();
                    end
                end else if (m_st == 2) begin
                    m_st = 3;
                end else if (m_st == 3) begin
                    m_st = 0; m_done = 1;
                end
                if (wr_en) begin m_hold = wr_data; m_full = 1; end
                else if (tak) m_full = 0;
            end
        end
    end

    // Every-cycle comparison against the reference and pulse counting.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_pulse) n_done++;
            if (buf_empty_pulse) n_emp++;
            if (mdl_on) begin
                chk(txd === m_txd, cur_req, "txd per-cycle", int'(txd), int'(m_txd));
                chk(buf_empty_pulse === m_emp, cur_req, "buf_empty per-cycle", int'(buf_empty_pulse), int'(m_emp));
                chk(done_pulse === m_done, cur_req, "done per-cycle", int'(done_pulse), int'(m_done));
            end
        end
    end

    task automatic write_word(input logic [7:0] w);
        @(negedge clk); wr_en = 1; wr_data = w;
        @(negedge clk); wr_en = 0;
    endtask

    // R2: load one edge after the strobe, buffer-empty pulse in the following cycle.
    task automatic write_chk(input logic [7:0] w);
        @(negedge clk); wr_en = 1; wr_data = w;
        @(negedge clk); wr_en = 0;
        chk(buf_empty_pulse == 0, "R2", "empty before load", int'(buf_empty_pulse), 0);
        @(negedge clk);
        chk(buf_empty_pulse == 1, "R2", "empty after load", int'(buf_empty_pulse), 1);
        chk(txd == 1, "R4", "line high before first edge", int'(txd), 1);
    endtask

    // Drive external clock cycles; sample txd just before each rising edge.
    task automatic ext_cycles(input int ncyc, input int half);
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk); ext_sck = 0;
            repeat (half) @(negedge clk);
            caps.push_back(txd);
            ext_sck = 1;
            repeat (half - 1) @(negedge clk);
        end
    endtask

    task automatic chk_bits(input int off, input logic [7:0] w, input int lo, input int n, input string req);
        for (int i = 0; i < n; i++)
            chk(caps[off + i] == w[lo + i], req, $sformatf("bit %0d", lo + i), int'(caps[off + i]), int'(w[lo + i]));
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            finish_run();
        end
    end

    initial begin : main
        int d0, e0, t;
        bit prev;
        repeat (3) @(negedge clk);
        chk(txd == 1, "R1", "txd in reset", int'(txd), 1);
        chk(done_pulse == 0 && buf_empty_pulse == 0, "R1", "pulses in reset", int'(done_pulse), 0);
        rst_n = 1;
        @(negedge clk);
        chk(txd == 1, "R1", "txd after reset", int'(txd), 1);
        chk(mst_sck == 1, "R11", "mst_sck in slave", int'(mst_sck), 1);
        repeat (3) @(negedge clk);

        // R3: exact latency from pin to line.
        cur_req = "R3";
        d0 = n_done;
        write_chk(8'hFE);
        @(negedge clk); ext_sck = 0;
        @(negedge clk);
        @(negedge clk);
        chk(txd == 1, "R3", "no change one edge after sample", int'(txd), 1);
        @(negedge clk);
        chk(txd == 0, "R3", "bit0 at second edge", int'(txd), 0);
        repeat (2) @(negedge clk); ext_sck = 1;
        repeat (5) @(negedge clk);
        caps.delete();
        ext_cycles(8, 5);
        chk_bits(0, 8'hFE, 1, 7, "R3");
        chk(caps[7] == 1, "R6", "high after frame", int'(caps[7]), 1);
        repeat (5) @(negedge clk);
        chk(n_done - d0 == 1, "R8", "done count", n_done - d0, 1);

        // R4 / R8: plain 8-bit frame.
        cur_req = "R4";
        d0 = n_done;
        write_chk(8'hA5);
        caps.delete();
        ext_cycles(9, 5);
        chk_bits(0, 8'hA5, 0, 8, "R4");
        chk(caps[8] == 1, "R6", "line high after last bit", int'(caps[8]), 1);
        repeat (5) @(negedge clk);
        chk(n_done - d0 == 1, "R8", "single done", n_done - d0, 1);
        chk(txd == 1, "R8", "idle line", int'(txd), 1);

        // R5: short, zero and oversize lengths; length captured at load.
        cur_req = "R5";
        frame_len = LW'(3);
        write_chk(8'h06);
        caps.delete();
        ext_cycles(4, 5);
        chk_bits(0, 8'h06, 0, 3, "R5");
        chk(caps[3] == 1, "R5", "3-bit frame closes", int'(caps[3]), 1);
        repeat (5) @(negedge clk);
        frame_len = LW'(0);
        write_chk(8'h3C);
        caps.delete();
        ext_cycles(9, 5);
        chk_bits(0, 8'h3C, 0, 8, "R5");
        chk(caps[8] == 1, "R5", "zero length gives full frame", int'(caps[8]), 1);
        repeat (5) @(negedge clk);
        frame_len = LW'(12);
        write_chk(8'hC3);
        frame_len = LW'(2);
        caps.delete();
        ext_cycles(9, 5);
        chk_bits(0, 8'hC3, 0, 8, "R5");
        chk(caps[8] == 1, "R5", "oversize length gives full frame", int'(caps[8]), 1);
        repeat (5) @(negedge clk);
        frame_len = LW'(8);

        // R7 / R10: queued word reloads without completion; later write replaces earlier.
        cur_req = "R7";
        d0 = n_done; e0 = n_emp;
        write_chk(8'h5A);
        write_word(8'h11);
        write_word(8'h96);
        caps.delete();
        ext_cycles(18, 5);
        chk_bits(0, 8'h5A, 0, 8, "R7");
        chk(caps[8] == 1, "R6", "gap high between frames", int'(caps[8]), 1);
        chk_bits(9, 8'h96, 0, 8, "R10");
        repeat (5) @(negedge clk);
        chk(n_done - d0 == 1, "R7", "one done for two frames", n_done - d0, 1);
        chk(n_emp - e0 == 2, "R7", "two empty pulses", n_emp - e0, 2);

        // R6: fast clock so a detected edge lands in the gap.
        cur_req = "R6";
        d0 = n_done;
        write_chk(8'hE7);
        write_word(8'h18);
        caps.delete();
        ext_cycles(30, 1);
        repeat (10) @(negedge clk);
        chk(n_done - d0 == 1, "R6", "fast back-to-back done", n_done - d0, 1);
        chk(txd == 1, "R6", "idle after fast frames", int'(txd), 1);

        // R9: stall the external clock, then drain through the internal clock.
        cur_req = "R9";
        d0 = n_done;
        write_chk(8'h9B);
        caps.delete();
        ext_cycles(3, 5);
        write_word(8'h4D);
        @(negedge clk); mdl_on = 0; slave_mode = 0;
        caps.delete();
        prev = mst_sck;
        t = 0;
        while (caps.size() < 14 && t < 3000) begin
            @(negedge clk); t++;
            if (mst_sck && !prev) caps.push_back(txd);
            prev = mst_sck;
        end
        chk(caps.size() == 14, "R9", "internal clock rises", caps.size(), 14);
        if (caps.size() == 14) begin
            chk_bits(0, 8'h9B, 3, 5, "R9");
            chk(caps[5] == 1, "R9", "gap high in master", int'(caps[5]), 1);
            chk_bits(6, 8'h4D, 0, 8, "R9");
        end
        t = 0;
        while (n_done == d0 && t < 3000) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk);
        chk(n_done - d0 == 1, "R9", "drain completes", n_done - d0, 1);
        chk(txd == 1, "R9", "idle after drain", int'(txd), 1);
        slave_mode = 1; mdl_on = 1;
        repeat (3) @(negedge clk);
        chk(mst_sck == 1, "R11", "mst_sck back high", int'(mst_sck), 1);
        d0 = n_done;
        write_chk(8'h71);
        caps.delete();
        ext_cycles(9, 5);
        chk_bits(0, 8'h71, 0, 8, "R9");
        repeat (5) @(negedge clk);
        chk(n_done - d0 == 1, "R9", "slave mode after drain", n_done - d0, 1);

        // R1: reset in mid-frame returns to idle.
        cur_req = "R1";
        write_chk(8'h00);
        ext_cycles(2, 5);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(txd == 1, "R1", "txd after mid-frame reset", int'(txd), 1);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule